// File: doc/BRIEF.md
# Sum-of-Products Product-Term Array

This block is the logic core of a small programmable logic device. Twelve dedicated inputs and ten feedback lines each enter the array in true and inverted form, giving 44 array lines. Each product term is a wide AND over whichever lines its configuration bits connect. Fixed, unevenly sized groups of terms are ORed into ten sum outputs. Separate single terms drive one enable per output, a global synchronous preset, a global asynchronous clear and a clock. The output cells, pin drivers and any non-volatile storage sit outside this block.

The configuration is one bit per line/term crossing, held in registers. An erase strobe opens every crossing in one cycle and returns the write pointer to the first bit. After that, one bit is written per clock while the load enable is high, in term-major order. Evaluation of the array is purely combinational from the inputs and the stored configuration.

Top module: `pla_sop_array`

## Requirements
- R1: After a synchronous active-low reset every crossing is open and the write pointer is at bit 0, so every sum, enable, preset, clear and clock output reads 1.
- R2: Array line numbering: dedicated input i drives line 2i (true) and line 2i+1 (inverted); feedback j drives line 24+2j (true) and line 25+2j (inverted). Configuration bit t*44+l connects line l to term t. Each clock with cfg_load_en high and cfg_erase low writes cfg_data to the bit at the pointer, then advances the pointer by one.
- R3: A product term is the AND of the lines it connects; a term with no connections reads 1.
- R4: A term connected to both the true and the inverted line of one signal reads 0 for every input value.
- R5: Terms 0 to 119 form the sum groups: output k ORs a run of consecutive terms whose sizes for k = 0..9 are 8, 10, 12, 14, 16, 16, 14, 12, 10, 8, starting at terms 0, 8, 18, 30, 44, 60, 76, 90, 102, 112.
- R6: A term with every crossing connected reads 0 and leaves its sum unaffected.
- R7: Term 120+k drives the enable of output k, term 130 the preset, term 131 the clear and term 132 the clock output.
- R8: cfg_erase opens every crossing and resets the pointer in one cycle, and it takes priority over a load in the same cycle.
- R9: With cfg_load_en and cfg_erase low the configuration does not change, whatever cfg_data does, while outputs follow the inputs in the same cycle.
- R10: After the last bit (index 5851) the pointer wraps to bit 0, so a second full load without an erase overwrites the image in alignment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration registers |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_erase | input | 1 | Opens all crossings and rewinds the pointer |
| cfg_load_en | input | 1 | Writes cfg_data at the pointer this clock |
| cfg_data | input | 1 | Serial configuration bit |
| ded_in | input | 12 | Dedicated inputs |
| fb_in | input | 10 | Feedback or I/O inputs |
| sum_out | output | 10 | OR of each output's term group |
| oe_out | output | 10 | Per-output enable terms |
| preset_term | output | 1 | Global synchronous preset term |
| clear_term | output | 1 | Global asynchronous clear term |
| clock_term | output | 1 | Clock term |

## Verification
Array results are combinational, so after a change on ded_in or fb_in at a falling edge the bench reads every output one nanosecond later in the same cycle. A configuration bit lands at the rising edge after it is presented, so the bench drives the last bit at a falling edge, waits for the next falling edge, and only then samples. Erase and reset take effect at one rising edge and are observed at the following falling edge. The alignment checks for erase priority and pointer wrap read the outputs after a whole image is loaded, because a pointer off by one bit would scramble every term.

// File: rtl/pla_pkg.sv
// Shared constants and group-layout functions for the product-term array.
// Assumes groups grow by a fixed step to the middle output, then mirror.
package pla_pkg;

    // Size of the sum group feeding output k.
    function automatic int grp_size(input int k, input int n_out,
                                    input int g_min, input int g_step);
        if (k < n_out / 2)
            return g_min + g_step * k;
        else
            return g_min + g_step * (n_out - 1 - k);
    endfunction

    // Index of the first term in the group feeding output k.
    function automatic int grp_base(input int k, input int n_out,
                                    input int g_min, input int g_step);
        int acc;
        acc = 0;
        for (int i = 0; i < k; i++)
            acc += grp_size(i, n_out, g_min, g_step);
        return acc;
    endfunction

endpackage

// File: rtl/pla_cfg_store.sv
// Configuration store: one register bit per crossing, written serially.
// Erase clears all bits and the pointer in one cycle and beats a load.
// Assumes the loader presents bits in term-major order.
module pla_cfg_store #(
    parameter int BITS = 5852
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_erase,
    input  logic            cfg_load_en,
    input  logic            cfg_data,
    output logic [BITS-1:0] cfg_bits
);
    localparam int PTR_W = $clog2(BITS);
    localparam logic [PTR_W-1:0] LAST = PTR_W'(BITS - 1);

    logic [PTR_W-1:0] ptr;

    // Clear on reset or erase, otherwise write one bit per enabled clock.
    always_ff @(posedge clk) begin
        if (!rst_n || cfg_erase) begin
            cfg_bits <= '0;
            ptr      <= '0;
        end else if (cfg_load_en) begin
            cfg_bits[ptr] <= cfg_data;
            ptr           <= (ptr == LAST) ? '0 : ptr + PTR_W'(1);
        end
    end

    assert_erase_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_erase |=> (cfg_bits == '0 && ptr == '0));

    assert_idle_holds_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_erase && !cfg_load_en) |=> $stable(cfg_bits));

    assert_ptr_advance_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_en && !cfg_erase && ptr != LAST) |=> ptr == $past(ptr) + PTR_W'(1));

    assert_ptr_wrap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_load_en && !cfg_erase && ptr == LAST) |=> ptr == '0);

endmodule

// File: rtl/pla_pterm.sv
// One product term: AND over the lines whose crossing bit is set.
// Open crossings are don't-cares, so an all-open term reads 1.
// Lines are paired true/inverted at even/odd positions.
module pla_pterm #(
    parameter int LINES = 44
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] lines,
    input  logic [LINES-1:0] conn,
    output logic             term
);
    // Wide AND with unconnected lines forced true.
    always_comb term = &(lines | ~conn);

    // Flags a term tied to both polarities of some signal (for checking only).
    logic both_pol;
    always_comb begin
        both_pol = 1'b0;
        for (int p = 0; p < LINES / 2; p++)
            if (conn[2*p] && conn[2*p+1]) both_pol = 1'b1;
    end

    assert_open_term_true_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (conn == '0) |-> term);

    assert_both_pol_false_R4: assert property (@(posedge clk) disable iff (!rst_n)
        both_pol |-> !term);

endmodule

// File: rtl/pla_sum_group.sv
// Fixed OR over one run of product terms feeding one sum output.
// Assumes unused terms were fully connected by the loader.
module pla_sum_group #(
    parameter int SIZE = 8
) (
    input  logic [SIZE-1:0] terms,
    output logic            sum
);
    // OR of all terms in the group.
    always_comb sum = |terms;
endmodule

// File: rtl/pla_sop_array.sv
// Top of the sum-of-products array: builds the true/inverted lines,
// instantiates every product term, ORs the sum groups and routes the
// special terms. Evaluation is combinational; only configuration is stored.
module pla_sop_array
    import pla_pkg::*;
#(
    parameter int N_DED  = 12,
    parameter int N_FB   = 10,
    parameter int G_MIN  = 8,
    parameter int G_STEP = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_erase,
    input  logic             cfg_load_en,
    input  logic             cfg_data,
    input  logic [N_DED-1:0] ded_in,
    input  logic [N_FB-1:0]  fb_in,
    output logic [N_FB-1:0]  sum_out,
    output logic [N_FB-1:0]  oe_out,
    output logic             preset_term,
    output logic             clear_term,
    output logic             clock_term
);
    localparam int LINES    = 2 * (N_DED + N_FB);
    localparam int SUM_T    = grp_base(N_FB, N_FB, G_MIN, G_STEP);
    localparam int OE_T0    = SUM_T;
    localparam int PRE_T    = OE_T0 + N_FB;
    localparam int CLR_T    = PRE_T + 1;
    localparam int CLK_T    = PRE_T + 2;
    localparam int TERMS    = PRE_T + 3;
    localparam int CFG_BITS = TERMS * LINES;

    logic [CFG_BITS-1:0] cfg_bits;
    logic [LINES-1:0]    lines;
    logic [TERMS-1:0]    terms;

    pla_cfg_store #(.BITS(CFG_BITS)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_erase   (cfg_erase),
        .cfg_load_en (cfg_load_en),
        .cfg_data    (cfg_data),
        .cfg_bits    (cfg_bits)
    );

    // Build array lines: dedicated pairs first, feedback pairs after.
    always_comb begin
        for (int i = 0; i < N_DED; i++) begin
            lines[2*i]   = ded_in[i];
            lines[2*i+1] = ~ded_in[i];
        end
        for (int j = 0; j < N_FB; j++) begin
            lines[2*N_DED + 2*j]     = fb_in[j];
            lines[2*N_DED + 2*j + 1] = ~fb_in[j];
        end
    end

    for (genvar t = 0; t < TERMS; t++) begin : g_term
        pla_pterm #(.LINES(LINES)) u_term (
            .clk   (clk),
            .rst_n (rst_n),
            .lines (lines),
            .conn  (cfg_bits[t*LINES +: LINES]),
            .term  (terms[t])
        );
    end

    for (genvar k = 0; k < N_FB; k++) begin : g_sum
        localparam int SZ   = grp_size(k, N_FB, G_MIN, G_STEP);
        localparam int BASE = grp_base(k, N_FB, G_MIN, G_STEP);
        pla_sum_group #(.SIZE(SZ)) u_grp (
            .terms (terms[BASE +: SZ]),
            .sum   (sum_out[k])
        );
    end

    // Route the single special terms.
    always_comb begin
        oe_out      = terms[OE_T0 +: N_FB];
        preset_term = terms[PRE_T];
        clear_term  = terms[CLR_T];
        clock_term  = terms[CLK_T];
    end

    assert_reset_open_R1: assert property (@(posedge clk)
        !rst_n |=> (sum_out == '1 && oe_out == '1 && preset_term && clear_term && clock_term));

endmodule

// File: tb/sim_pla_sop_array.sv
module sim_pla_sop_array;
    localparam int NL   = 44;
    localparam int NT   = 133;
    localparam int BITS = NT * NL;
    localparam int BASE [10] = '{0, 8, 18, 30, 44, 60, 76, 90, 102, 112};
    localparam int LAST [10] = '{7, 17, 29, 43, 59, 75, 89, 101, 111, 119};

    // {ded[11:0], fb[9:0], sum[9:0], oe[9:0], preset, clear, clock}
    localparam logic [44:0] VEC [6] = '{
        {12'h000, 10'h000, 10'h3FF, 10'h000, 3'b011},
        {12'hFFF, 10'h3FF, 10'h3FF, 10'h3FF, 3'b110},
        {12'h000, 10'h3FF, 10'h000, 10'h3FF, 3'b011},
        {12'h155, 10'h3FF, 10'h155, 10'h3FF, 3'b011},
        {12'hC2A, 10'h0F0, 10'h32F, 10'h0F0, 3'b110},
        {12'h800, 10'h200, 10'h1FF, 10'h200, 3'b010}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_erase = 1'b0, cfg_load_en = 1'b0, cfg_data = 1'b0;
    logic [11:0] ded_in = '0;
    logic [9:0]  fb_in = '0;
    logic [9:0]  sum_out, oe_out;
    logic preset_term, clear_term, clock_term;
    logic [BITS-1:0] img;
    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    pla_sop_array u0 (
        .clk(clk), .rst_n(rst_n), .cfg_erase(cfg_erase), .cfg_load_en(cfg_load_en),
        .cfg_data(cfg_data), .ded_in(ded_in), .fb_in(fb_in), .sum_out(sum_out),
        .oe_out(oe_out), .preset_term(preset_term), .clear_term(clear_term),
        .clock_term(clock_term)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic open_term(input int t);
        for (int l = 0; l < NL; l++) img[t*NL + l] = 1'b0;
    endtask

    task automatic connect(input int t, input int l);
        img[t*NL + l] = 1'b1;
    endtask

    task automatic load_img();
        for (int b = 0; b < BITS; b++) begin
            @(negedge clk);
            cfg_load_en = 1'b1;
            cfg_data    = img[b];
        end
        @(negedge clk);
        cfg_load_en = 1'b0;
        cfg_data    = 1'b0;
    endtask

    task automatic do_erase(input logic with_load);
        @(negedge clk);
        cfg_erase   = 1'b1;
        cfg_load_en = with_load;
        cfg_data    = 1'b1;
        @(negedge clk);
        cfg_erase   = 1'b0;
        cfg_load_en = 1'b0;
        cfg_data    = 1'b0;
    endtask

    // Image A: sum[k] = ded[k] | ~fb[k]; oe[k] = fb[k]; preset = ded10&ded11;
    // clear open (1); clock = ~ded11. All other terms fully connected.
    task automatic build_a();
        img = '1;
        for (int k = 0; k < 10; k++) begin
            open_term(BASE[k]); connect(BASE[k], 2*k);
            open_term(LAST[k]); connect(LAST[k], 25 + 2*k);
            open_term(120 + k); connect(120 + k, 24 + 2*k);
        end
        open_term(130); connect(130, 20); connect(130, 22);
        open_term(131);
        open_term(132); connect(132, 23);
    endtask

    // Image B: term 0 tied to ded0 both polarities; term 8 open; rest full.
    task automatic build_b();
        img = '1;
        open_term(0); connect(0, 0); connect(0, 1);
        open_term(8);
    endtask

    task automatic apply(input logic [11:0] d, input logic [9:0] f);
        @(negedge clk);
        ded_in = d;
        fb_in  = f;
        #1;
    endtask

    task automatic run_vec(input int i, input string req);
        apply(VEC[i][44:33], VEC[i][32:23]);
        check(req, 32'(sum_out), 32'(VEC[i][22:13]));
        check("R7 oe", 32'(oe_out), 32'(VEC[i][12:3]));
        check("R7 special", 32'({preset_term, clear_term, clock_term}), 32'(VEC[i][2:0]));
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        apply(12'hA5A, 10'h155);
        check("R1 sum", 32'(sum_out), 32'h3FF);
        check("R1 oe", 32'(oe_out), 32'h3FF);
        check("R1 special", 32'({preset_term, clear_term, clock_term}), 32'h7);

        // Main table with image A.
        build_a();
        load_img();
        for (int i = 0; i < 6; i++) run_vec(i, "R2 R3 R5 sum");

        // R9: toggling cfg_data with load disabled changes nothing.
        apply(12'hC2A, 10'h0F0);
        for (int c = 0; c < 20; c++) begin
            @(negedge clk);
            cfg_data = ~cfg_data;
        end
        #1;
        check("R9 sum held", 32'(sum_out), 32'h32F);
        check("R9 oe held", 32'(oe_out), 32'h0F0);
        apply(12'h000, 10'h3FF);
        check("R9 same-cycle follow", 32'(sum_out), 32'h000);

        // R8: erase opens everything.
        do_erase(1'b0);
        #1;
        check("R8 erase sum", 32'(sum_out), 32'h3FF);
        check("R8 erase oe", 32'(oe_out), 32'h3FF);

        // R4 R6 R3 with image B.
        build_b();
        load_img();
        apply(12'h000, 10'h000);
        check("R4 R6 R3 sum ded0=0", 32'(sum_out), 32'h002);
        apply(12'hFFF, 10'h3FF);
        check("R4 R6 R3 sum ded0=1", 32'(sum_out), 32'h002);
        check("R6 oe full", 32'(oe_out), 32'h000);

        // R10: reload image A without erase; pointer wrapped so it aligns.
        build_a();
        load_img();
        run_vec(4, "R10 wrap sum");

        // R8 priority: erase with load high must not advance the pointer.
        do_erase(1'b1);
        #1;
        check("R8 priority erase", 32'(sum_out), 32'h3FF);
        load_img();
        run_vec(5, "R8 priority aligned");

        // R1: reset in mid-configuration reopens everything.
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R1 reset again", 32'({sum_out, oe_out}), 32'hFFFFF);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (190000) @(posedge clk);
                n_chk++;
                n_bad++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule